// File: doc/BRIEF.md
# Ascending Multi-Register Store Sequencer

This block runs one decoded store-multiple operation. It takes an instruction word and a two-bit format selector. It extracts a register-set bitmask, a base register index and a writeback flag. Then it visits the selected registers from the lowest number to the highest. For each one it reads the register file and issues one 32-bit word write on a valid/ready memory port. The addresses start at the base register's value and rise by 4 bytes per word.

After the last write is accepted, the block spends one cycle on completion. In that cycle it signals done and, if writeback was requested, it also presents the base register's new value.

Illegal combinations do not touch memory or the register file. The block reports them on a one-cycle undefined-instruction pulse instead.

The base register's value is supplied by the caller on `base_val_i` in the same cycle as `start_i`. The block captures it only then.

Top module: `mstore_seq`

## Requirements
- R1: The selected registers are written in ascending register-number order. The first write goes to the captured base value, and each following write goes to the previous address plus 4.
- R2: With writeback on, the completion cycle asserts `wb_en_o` with `wb_idx_o` equal to the base index. In that cycle `wb_data_o` equals the captured base plus 4 times the number of set bits in the register set. With writeback off, `wb_en_o` stays low and `done_o` still pulses.
- R3: Format 0 (wide), selected by `fmt_i`=0:
  - the register set is `insn_i[15:0]` (bit i selects register i);
  - the base index is `insn_i[19:16]`;
  - writeback is `insn_i[21]`.
- R4: Format 1 (narrow), selected by `fmt_i`=1:
  - the register set is `insn_i[7:0]`, zero-extended to 16 bits;
  - the base index is `insn_i[10:8]`;
  - writeback is always on;
  - `insn_i[31:11]` has no effect.
- R5: Format 2 (32-bit compact), selected by `fmt_i`=2:
  - set bit 15 is `insn_i[15]`, set bit 14 (link register) is `insn_i[14]`, set bit 13 is `insn_i[13]`, and set bits 12..0 are `insn_i[12:0]`;
  - the base index is `insn_i[19:16]`;
  - writeback is `insn_i[21]`.
- R6: Register 15, when selected, is written last at the highest address, and the data written is `pc_store_i`.
- R7: Consider the case where writeback is on and the base register is in the set. If the base is not the lowest set bit, its word is written as 32'h0 and the address still advances. If the base is the lowest set bit, its real register value is written.
- R8: The operation is undefined in each of these cases:
  - the base index is 15;
  - the register set is empty;
  - in format 2, fewer than two registers are set;
  - in format 2, set bit 13 or set bit 15 is present;
  - in format 2, writeback is on and the base is in the set;
  - `fmt_i` is 3.

  An undefined operation raises `undef_o` for exactly one cycle, starting one cycle after start. It makes no write, no writeback and no `done_o`.
- R9: While `mem_ready_i` is low, `mem_valid_o`, `mem_addr_o` and `rf_rd_idx_o` hold. With `mem_ready_i` held high, `done_o` appears exactly N+1 cycles after the start edge, where N is the register count, whatever the data values.
- R10: `start_i` is ignored from the start edge until `done_o` has been presented.
- R11: `base_val_i` is sampled only at start. Later changes alter neither the addresses nor the writeback value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| fmt_i | input | 2 | Instruction format: 0 wide, 1 narrow, 2 32-bit compact, 3 invalid |
| insn_i | input | 32 | Instruction word |
| base_val_i | input | 32 | Value of the base register, sampled at start |
| pc_store_i | input | 32 | Value written for register 15 |
| rf_rd_idx_o | output | 4 | Register file read index |
| rf_rd_data_i | input | 32 | Register file read data for `rf_rd_idx_o` |
| mem_valid_o | output | 1 | Write request valid |
| mem_addr_o | output | 32 | Write byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Write accepted when high with valid |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| wb_en_o | output | 1 | Base register write enable |
| wb_idx_o | output | 4 | Base register index to write |
| wb_data_o | output | 32 | New base register value |
| undef_o | output | 1 | Undefined-instruction pulse |

## Verification
The bench targets two base-in-set cases under writeback. If the base is not the lowest set bit, a wrong design would leak the real register value instead of zero. If the base is the lowest set bit, a wrong design would write zero where the real value belongs.

The bench also checks that register 15 takes the supplied PC value at the top address. It checks that the narrow format ignores its upper bits, and that each undefined case stays silent on the memory and writeback ports; a faulty decoder would store or write back there.

Finally, the bench holds `start_i` high during a run, stalls the memory port, and changes the base input mid-run. A design that restarts, skips a word or re-reads the base would then show wrong addresses or a wrong writeback sum.

// File: rtl/mstore_pkg.sv
package mstore_pkg;
    typedef enum logic [1:0] {
        FMT_WIDE   = 2'd0,
        FMT_NARROW = 2'd1,
        FMT_CMP32  = 2'd2,
        FMT_BAD    = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STORE = 2'd1,
        ST_FIN   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/mstore_lowbit.sv
module mstore_lowbit #(
    parameter int N    = 16,
    localparam int IW  = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    logic [N:0]   seen;
    logic [N-1:0] first;

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign first[g]  = vec_i[g] & ~seen[g];
        assign seen[g+1] = seen[g] | vec_i[g];
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx_o = idx_o | IW'(i);
        end
    end

    assign any_o = seen[N];
endmodule

// File: rtl/mstore_decode.sv
module mstore_decode
    import mstore_pkg::*;
#(
    parameter int NREG  = 16,
    localparam int IW   = $clog2(NREG),
    localparam int CW   = IW + 1
) (
    input  logic [1:0]      fmt_i,
    input  logic [31:0]     insn_i,
    output logic [NREG-1:0] set_o,
    output logic [IW-1:0]   base_o,
    output logic            wb_o,
    output logic [CW-1:0]   cnt_o,
    output logic            bad_o
);
    localparam int SP_BIT = NREG - 3;
    localparam int PC_BIT = NREG - 1;

    always_comb begin
        set_o  = '0;
        base_o = '0;
        wb_o   = 1'b0;
        unique case (fmt_e'(fmt_i))
            FMT_WIDE: begin
                set_o  = insn_i[NREG-1:0];
                base_o = insn_i[16 +: IW];
                wb_o   = insn_i[21];
            end
            FMT_NARROW: begin
                set_o  = NREG'(insn_i[7:0]);
                base_o = IW'(insn_i[10:8]);
                wb_o   = 1'b1;
            end
            FMT_CMP32: begin
                set_o  = {insn_i[15], insn_i[14], insn_i[13], insn_i[12:0]};
                base_o = insn_i[16 +: IW];
                wb_o   = insn_i[21];
            end
            default: ;
        endcase
    end

    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < NREG; i++) cnt_o = cnt_o + CW'(set_o[i]);
    end

    always_comb begin
        bad_o = (cnt_o == '0) || (base_o == IW'(PC_BIT)) || (fmt_e'(fmt_i) == FMT_BAD);
        if (fmt_e'(fmt_i) == FMT_CMP32) begin
            if (cnt_o < CW'(2) || set_o[SP_BIT] || set_o[PC_BIT] || (wb_o && set_o[base_o]))
                bad_o = 1'b1;
        end
    end
endmodule

// File: rtl/mstore_seq.sv
module mstore_seq
    import mstore_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREG  = 16,
    localparam int IW   = $clog2(NREG),
    localparam int CW   = IW + 1,
    localparam int STEP = XLEN / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      fmt_i,
    input  logic [31:0]     insn_i,
    input  logic [XLEN-1:0] base_val_i,
    input  logic [XLEN-1:0] pc_store_i,
    output logic [IW-1:0]   rf_rd_idx_o,
    input  logic [XLEN-1:0] rf_rd_data_i,
    output logic            mem_valid_o,
    output logic [XLEN-1:0] mem_addr_o,
    output logic [XLEN-1:0] mem_wdata_o,
    input  logic            mem_ready_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            wb_en_o,
    output logic [IW-1:0]   wb_idx_o,
    output logic [XLEN-1:0] wb_data_o,
    output logic            undef_o
);
    typedef struct packed {
        seq_state_e      st;
        logic [NREG-1:0] mask;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] base;
        logic [IW-1:0]   bidx;
        logic [IW-1:0]   low;
        logic            wb;
        logic [CW-1:0]   cnt;
        logic            undef;
    } ctx_t;

    ctx_t c_d, c_q;

    logic [NREG-1:0] dec_set;
    logic [IW-1:0]   dec_base, dec_low, cur_idx;
    logic            dec_wb, dec_bad, dec_any, cur_any;
    logic [CW-1:0]   dec_cnt;
    logic            last_w;

    mstore_decode #(.NREG(NREG)) i_dec (
        .fmt_i (fmt_i),
        .insn_i(insn_i),
        .set_o (dec_set),
        .base_o(dec_base),
        .wb_o  (dec_wb),
        .cnt_o (dec_cnt),
        .bad_o (dec_bad)
    );

    mstore_lowbit #(.N(NREG)) i_low_dec (
        .vec_i(dec_set),
        .idx_o(dec_low),
        .any_o(dec_any)
    );

    mstore_lowbit #(.N(NREG)) i_low_cur (
        .vec_i(c_q.mask),
        .idx_o(cur_idx),
        .any_o(cur_any)
    );

    assign last_w = (c_q.mask & (c_q.mask - NREG'(1))) == '0;

    always_comb begin
        c_d       = c_q;
        c_d.undef = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (dec_bad || !dec_any) begin
                        c_d.undef = 1'b1;
                    end else begin
                        c_d.st   = ST_STORE;
                        c_d.mask = dec_set;
                        c_d.addr = base_val_i;
                        c_d.base = base_val_i;
                        c_d.bidx = dec_base;
                        c_d.low  = dec_low;
                        c_d.wb   = dec_wb;
                        c_d.cnt  = dec_cnt;
                    end
                end
            end
            ST_STORE: begin
                if (mem_ready_i) begin
                    c_d.mask = c_q.mask & (c_q.mask - NREG'(1));
                    c_d.addr = c_q.addr + XLEN'(STEP);
                    if (last_w) c_d.st = ST_FIN;
                end
            end
            ST_FIN:  c_d.st = ST_IDLE;
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q    <= c_d;
        end
    end

    always_comb begin
        mem_wdata_o = rf_rd_data_i;
        if (cur_idx == IW'(NREG - 1))
            mem_wdata_o = pc_store_i;
        else if (c_q.wb && cur_idx == c_q.bidx && cur_idx != c_q.low)
            mem_wdata_o = '0;
    end

    assign rf_rd_idx_o = cur_idx;
    assign mem_valid_o = (c_q.st == ST_STORE) && cur_any;
    assign mem_addr_o  = c_q.addr;
    assign busy_o      = (c_q.st != ST_IDLE);
    assign done_o      = (c_q.st == ST_FIN);
    assign wb_en_o     = done_o && c_q.wb;
    assign wb_idx_o    = c_q.bidx;
    assign wb_data_o   = c_q.base + XLEN'(c_q.cnt) * XLEN'(STEP);
    assign undef_o     = c_q.undef;

    // R1: accepted non-final store is followed by the next word address
    a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && mem_ready_i && !last_w |=>
            mem_valid_o && mem_addr_o == $past(mem_addr_o) + XLEN'(STEP));

    // R2: final acceptance leads to completion, writeback one word above last address
    a_r2_wb_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && mem_ready_i && last_w |=>
            done_o && !mem_valid_o && (!wb_en_o || wb_data_o == $past(mem_addr_o) + XLEN'(STEP)));

    // R6: register 15 is always the final store
    a_r6_pc_last: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && mem_ready_i && rf_rd_idx_o == IW'(NREG - 1) |=> !mem_valid_o && done_o);

    // R8: undefined pulse never coincides with traffic, and lasts one cycle
    a_r8_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> !mem_valid_o && !wb_en_o && !done_o && !busy_o);
    a_r8_undef_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |=> !undef_o);

    // R9: a stalled request holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && !mem_ready_i |=>
            mem_valid_o && $stable(mem_addr_o) && $stable(rf_rd_idx_o));

    // R10: start while busy does not restart the walk
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o && mem_valid_o && !mem_ready_i |=> $stable(mem_addr_o));
endmodule

// File: tb/test_mstore_seq.sv
module test_mstore_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  fmt_i = 2'd0;
    logic [31:0] insn_i = '0;
    logic [31:0] base_val_i = '0;
    logic [31:0] pc_store_i = 32'h0000_8008;
    logic [3:0]  rf_rd_idx_o;
    logic [31:0] rf_rd_data_i;
    logic        mem_valid_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic        mem_ready_i = 1'b0;
    logic        busy_o, done_o, wb_en_o, undef_o;
    logic [3:0]  wb_idx_o;
    logic [31:0] wb_data_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #5 clk = ~clk;

    function automatic logic [31:0] rf_val(input logic [3:0] i);
        return 32'hC0DE_0000 | (32'(i) * 32'h0000_0101) | 32'h0000_0010;
    endfunction

    assign rf_rd_data_i = rf_val(rf_rd_idx_o);

    mstore_seq i_mstore_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fmt_i(fmt_i), .insn_i(insn_i),
        .base_val_i(base_val_i), .pc_store_i(pc_store_i), .rf_rd_idx_o(rf_rd_idx_o),
        .rf_rd_data_i(rf_rd_data_i), .mem_valid_o(mem_valid_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .busy_o(busy_o),
        .done_o(done_o), .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o),
        .undef_o(undef_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Runs one operation; bench decodes it independently from the requirements.
    task automatic run_op(input string req, input logic [1:0] fmt, input logic [31:0] insn,
                          input logic [31:0] base, input bit stall, input bit hold_start);
        logic [15:0] set;
        logic [3:0]  bidx;
        logic        wb, bad;
        int          cnt, low, k, it, acc;
        logic [3:0]  order [16];
        bit          finished;
        set = '0; bidx = '0; wb = 0;
        case (fmt)
            2'd0: begin set = insn[15:0]; bidx = insn[19:16]; wb = insn[21]; end
            2'd1: begin set = {8'h00, insn[7:0]}; bidx = {1'b0, insn[10:8]}; wb = 1; end
            2'd2: begin set = insn[15:0]; bidx = insn[19:16]; wb = insn[21]; end
            default: ;
        endcase
        cnt = 0; low = -1;
        for (int i = 0; i < 16; i++) if (set[i]) begin
            order[cnt] = 4'(i); cnt++;
            if (low < 0) low = i;
        end
        bad = (cnt == 0) || (bidx == 4'd15) || (fmt == 2'd3);
        if (fmt == 2'd2 && (cnt < 2 || set[13] || set[15] || (wb && set[bidx]))) bad = 1;

        @(negedge clk);
        fmt_i = fmt; insn_i = insn; base_val_i = base; start_i = 1'b1;
        mem_ready_i = !stall;
        k = 0; acc = 0; finished = 0;
        for (it = 1; it < 200 && !finished; it++) begin
            @(negedge clk);
            if (hold_start) begin fmt_i = 2'd0; insn_i = 32'h0020_0003; end
            else start_i = 1'b0;
            base_val_i = 32'hDEAD_0000 + 32'(it);      // R11: later base changes ignored
            if (bad) begin
                check({req, " R8 undef pulse"}, 32'(undef_o), 32'd1);
                check({req, " R8 no store"}, 32'(mem_valid_o), 32'd0);
                check({req, " R8 no done"}, 32'(done_o | wb_en_o), 32'd0);
                finished = 1;
            end else if (done_o) begin
                check({req, " R1 store count"}, 32'(k), 32'(cnt));
                check({req, " R2 wb enable"}, 32'(wb_en_o), 32'(wb));
                if (wb) begin
                    check({req, " R2 wb index"}, 32'(wb_idx_o), 32'(bidx));
                    check({req, " R2 R11 wb value"}, wb_data_o, base + 32'(4 * cnt));
                end
                if (!stall) check({req, " R9 cycles"}, 32'(it), 32'(cnt + 1));
                finished = 1;
            end else if (mem_valid_o) begin
                logic [31:0] ed;
                if (order[k] == 4'd15) ed = pc_store_i;                            // R6
                else if (wb && order[k] == bidx && 32'(order[k]) != 32'(low)) ed = '0;  // R7
                else ed = rf_val(order[k]);
                check({req, " R1 address"}, mem_addr_o, base + 32'(4 * k));
                check({req, " R1 R7 data"}, mem_wdata_o, ed);
                if (stall) begin
                    acc++;
                    mem_ready_i = acc[0];                       // R9: alternate stalls
                end
                if (mem_ready_i) k++;
            end
        end
        if (!finished) check({req, " completion"}, 32'd0, 32'd1);
        start_i = 1'b0; mem_ready_i = 1'b0;
        @(negedge clk);
        check({req, " R8 R10 idle after"}, 32'({busy_o, undef_o, mem_valid_o}), 32'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R9 reset idle", 32'({busy_o, mem_valid_o, done_o, wb_en_o, undef_o}), 32'd0);
    endtask

    task automatic t_wide;
        run_op("R3 wide wb", 2'd0, 32'h0023_00A5, 32'h0000_1000, 0, 0);
        run_op("R3 R6 wide pc no wb", 2'd0, 32'h0004_8012, 32'h0000_2000, 1, 0);
        run_op("R7 base not lowest", 2'd0, 32'h0024_0036, 32'h0000_3000, 0, 0);
        run_op("R7 base lowest", 2'd0, 32'h0024_0030, 32'h0000_3100, 0, 0);
        run_op("R3 R9 all sixteen", 2'd0, 32'h0020_FFFF, 32'h0001_0000, 0, 0);
    endtask

    task automatic t_narrow;
        run_op("R4 narrow", 2'd1, 32'hFFFF_F5C3, 32'h0000_4000, 0, 0);
        run_op("R4 R7 narrow base in set", 2'd1, 32'h0000_0246, 32'h0000_4400, 0, 0);
    endtask

    task automatic t_cmp32;
        run_op("R5 cmp32 link", 2'd2, 32'h0029_4006, 32'h0000_5000, 0, 0);
        run_op("R5 cmp32 base in set no wb", 2'd2, 32'h0001_0003, 32'h0000_5100, 0, 0);
    endtask

    task automatic t_undef;
        run_op("R8 base 15", 2'd0, 32'h002F_0003, 32'h0000_6000, 0, 0);
        run_op("R8 empty wide", 2'd0, 32'h0021_0000, 32'h0000_6000, 0, 0);
        run_op("R8 empty narrow", 2'd1, 32'h0000_0300, 32'h0000_6000, 0, 0);
        run_op("R8 cmp32 single", 2'd2, 32'h0002_0010, 32'h0000_6000, 0, 0);
        run_op("R8 cmp32 r13", 2'd2, 32'h0002_2001, 32'h0000_6000, 0, 0);
        run_op("R8 cmp32 r15", 2'd2, 32'h0002_8001, 32'h0000_6000, 0, 0);
        run_op("R8 cmp32 wb base in set", 2'd2, 32'h0021_0006, 32'h0000_6000, 0, 0);
        run_op("R8 format 3", 2'd3, 32'h0021_0006, 32'h0000_6000, 0, 0);
    endtask

    task automatic t_busy;
        run_op("R10 R11 start held while busy", 2'd0, 32'h0025_0521, 32'h0000_7000, 1, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wide();
        t_narrow();
        t_cmp32();
        t_undef();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule